// File: doc/BRIEF.md
# Constant Cache Broadcast Splitter

This block serves one warp-wide read of a small read-only constant space. A request carries one word address per lane and an active mask. The block finds the distinct addresses among the active lanes. It serves them one per cycle through a small direct-mapped cache of 32-bit words. Each returned word is written into the result slot of every active lane that asked for that address. When all active lanes share one address, the request costs a single access. In general the cost grows with the number of distinct addresses.

A miss stalls the sequence. The block issues a request on a backing-memory port with a valid/ready handshake and waits for the response. It fills the cache line and broadcasts the returned word in the same step. When every active lane holds its word, the block raises a one-cycle done strobe. At that point the result vector is valid, along with two counters: the number of sub-requests the request needed and the number of those that missed.

Top module: `ccb_splitter`

## Requirements
- R1: After reset `req_ready` is 1, `done` is 0 and `mem_req_valid` is 0. Every cache line is invalid, so the first access to any address misses.
- R2: When `done` is 1, lane i of `result` (bits i*DW upward) holds the backing-memory word at lane i's address (bits i*AW upward of `req_addr`) for every active lane. Every inactive lane holds zero.
- R3: `sub_count` equals the number of distinct addresses among the active lanes. A request whose active lanes all share one address gives 1.
- R4: `miss_count` counts the sub-requests whose line was not valid with a matching tag when accessed. The line index is the address modulo LINES and the tag is the remaining upper bits. A miss fills its line, so a later access to the same address hits.
- R5: A miss to an address that shares a line with a cached address replaces that line. A later access to the replaced address misses again.
- R6: Sub-requests are served in order of the lowest-numbered active lane whose address is not yet served. Misses therefore reach memory in that order, with one outstanding at a time. `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen.
- R7: A request with N distinct addresses that all hit raises `done` exactly N+2 cycles after the accepting edge. This includes N=0 for an empty mask, which gives zero counts and an all-zero result.
- R8: `done` is high for exactly one cycle. `req_ready` is high only while idle, and `req_valid` has no effect while the block is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A warp request is presented |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_mask | input | LANES | Active lane mask |
| req_addr | input | LANES*AW | Word address per lane, lane i at bits i*AW |
| mem_req_valid | output | 1 | Backing-memory read request |
| mem_req_ready | input | 1 | Backing memory takes the request |
| mem_req_addr | output | AW | Address of the missing word |
| mem_rsp_valid | input | 1 | Backing-memory word is returned |
| mem_rsp_data | input | DW | Returned word |
| done | output | 1 | One-cycle strobe: results and counters valid |
| result | output | LANES*DW | Result word per lane, lane i at bits i*DW |
| sub_count | output | $clog2(LANES+1) | Sub-requests issued for the last request |
| miss_count | output | $clog2(LANES+1) | Sub-requests of the last request that missed |

## Verification
The hardest case to reach from the ports is a miss inside a divergent request whose line a lower-numbered lane has just claimed with a different tag. Getting there needs the cache filled in an exact order before the request arrives. The bench sweeps every active mask of a narrowed configuration over address patterns that repeat and alias in the small cache. It tracks the cache contents in its own model so that hits, misses, replacements and the order of memory requests are all predicted. The memory model varies its ready stall and response delay from one request to the next, and one request drives new inputs while the block is busy.

// File: rtl/ccb_pkg.sv
// Shared types for the constant cache broadcast splitter.
package ccb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a warp request
        ST_LOOK,   // pick next unserved address and probe the cache
        ST_MISS,   // memory request presented
        ST_WAIT,   // waiting for the memory word
        ST_DONE    // one-cycle completion strobe
    } ccb_state_t;
endpackage

// File: rtl/ccb_pick.sv
// Selects the address of the lowest-numbered pending lane and marks every
// pending lane that requests that same address.
// Assumes: pending is a subset of the active mask; purely combinational.
module ccb_pick #(
    parameter int LANES = 32,
    parameter int AW    = 12
) (
    input  logic [LANES-1:0]    pending,
    input  logic [LANES*AW-1:0] addrs,
    output logic                any,
    output logic [AW-1:0]       sel_addr,
    output logic [LANES-1:0]    match
);
    // Priority pick: the lowest pending lane wins.
    always_comb begin
        any      = 1'b0;
        sel_addr = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i]) begin
                any      = 1'b1;
                sel_addr = addrs[i*AW +: AW];
            end
        end
    end

    // Per-lane compare: mark pending lanes that share the chosen address.
    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign match[g] = pending[g] && (addrs[g*AW +: AW] == sel_addr);
    end
endmodule

// File: rtl/ccb_store.sv
// Direct-mapped read-only word cache: combinational probe, one fill port.
// Assumes: LINES is a power of two smaller than 2**AW; valid bits clear on reset.
module ccb_store #(
    parameter int AW    = 12,
    parameter int DW    = 32,
    parameter int LINES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic          hit,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    localparam int IW = $clog2(LINES);
    localparam int TW = AW - IW;

    logic [LINES-1:0] valid_q;
    logic [TW-1:0]    tag_q  [LINES];
    logic [DW-1:0]    data_q [LINES];

    logic [IW-1:0] rd_idx, wr_idx;
    assign rd_idx = rd_addr[IW-1:0];
    assign wr_idx = wr_addr[IW-1:0];

    // Probe: hit when the indexed line is valid and its tag matches.
    assign hit     = valid_q[rd_idx] && (tag_q[rd_idx] == rd_addr[AW-1:IW]);
    assign rd_data = data_q[rd_idx];

    // Valid bits: cleared by reset, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n)     valid_q <= '0;
        else if (wr_en) valid_q[wr_idx] <= 1'b1;
    end

    // Tag and data arrays: written on a fill only.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_addr[AW-1:IW];
            data_q[wr_idx] <= wr_data;
        end
    end

    // R4
    fill_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/ccb_splitter.sv
// Warp constant read: splits a request into one cache access per distinct
// address, fetches misses from backing memory and broadcasts each word to
// all matching lanes. Assumes memory answers each accepted request with
// exactly one response and never responds unasked.
module ccb_splitter #(
    parameter int LANES = 32,
    parameter int AW    = 12,
    parameter int DW    = 32,
    parameter int LINES = 16,
    localparam int CW   = $clog2(LANES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [LANES-1:0]    req_mask,
    input  logic [LANES*AW-1:0] req_addr,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [AW-1:0]       mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [DW-1:0]       mem_rsp_data,
    output logic                done,
    output logic [LANES*DW-1:0] result,
    output logic [CW-1:0]       sub_count,
    output logic [CW-1:0]       miss_count
);
    import ccb_pkg::*;

    ccb_state_t          st_q;
    logic [LANES*AW-1:0] addr_q;
    logic [LANES-1:0]    pend_q;
    logic [LANES*DW-1:0] res_q;
    logic [CW-1:0]       sub_q, miss_q;

    logic             any, hit, serve, fill;
    logic [AW-1:0]    sel_addr;
    logic [LANES-1:0] match;
    logic [DW-1:0]    rd_data, serve_data;

    ccb_pick #(.LANES(LANES), .AW(AW)) u_pick (
        .pending(pend_q), .addrs(addr_q),
        .any(any), .sel_addr(sel_addr), .match(match)
    );

    ccb_store #(.AW(AW), .DW(DW), .LINES(LINES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(sel_addr), .hit(hit), .rd_data(rd_data),
        .wr_en(fill), .wr_addr(sel_addr), .wr_data(mem_rsp_data)
    );

    // Serve step: a cache hit while probing, or a memory word arriving.
    assign fill       = (st_q == ST_WAIT) && mem_rsp_valid;
    assign serve      = ((st_q == ST_LOOK) && any && hit) || fill;
    assign serve_data = fill ? mem_rsp_data : rd_data;

    // Sequencer: accept, probe per distinct address, fetch misses, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
            pend_q <= '0;
            res_q  <= '0;
            sub_q  <= '0;
            miss_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (req_valid) begin
                    addr_q <= req_addr;
                    pend_q <= req_mask;
                    res_q  <= '0;
                    sub_q  <= '0;
                    miss_q <= '0;
                    st_q   <= ST_LOOK;
                end
                ST_LOOK: if (!any) begin
                    st_q <= ST_DONE;
                end else begin
                    sub_q <= sub_q + 1'b1;
                    if (!hit) begin
                        miss_q <= miss_q + 1'b1;
                        st_q   <= ST_MISS;
                    end
                end
                ST_MISS: if (mem_req_ready) st_q <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) st_q <= ST_LOOK;
                default: st_q <= ST_IDLE;
            endcase
            if (serve) begin
                pend_q <= pend_q & ~match;
                for (int i = 0; i < LANES; i++) begin
                    if (match[i]) res_q[i*DW +: DW] <= serve_data;
                end
            end
        end
    end

    assign req_ready     = (st_q == ST_IDLE);
    assign done          = (st_q == ST_DONE);
    assign mem_req_valid = (st_q == ST_MISS);
    assign mem_req_addr  = sel_addr;
    assign result        = res_q;
    assign sub_count     = sub_q;
    assign miss_count    = miss_q;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
    // R8
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);
    // R4
    miss_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_count <= sub_count);
    // R3
    serve_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serve |=> (pend_q & $past(match)) == '0);
endmodule

// File: tb/ccb_splitter_tb.sv
module ccb_splitter_tb;
    localparam int LANES = 8;
    localparam int AW    = 6;
    localparam int DW    = 32;
    localparam int LINES = 8;
    localparam int CW    = $clog2(LANES + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [LANES-1:0] req_mask = '0;
    logic [LANES*AW-1:0] req_addr = '0;
    logic mem_req_valid;
    logic mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic done;
    logic [LANES*DW-1:0] result;
    logic [CW-1:0] sub_count, miss_count;

    ccb_splitter #(.LANES(LANES), .AW(AW), .DW(DW), .LINES(LINES)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mask(req_mask), .req_addr(req_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .result(result),
        .sub_count(sub_count), .miss_count(miss_count)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0, cycles = 0;
    int stall = 0, lat = 0;
    logic [AW-1:0] act_miss [64];
    int act_n = 0;
    logic [AW-1:0] exp_miss [64];
    int exp_n;
    logic mval [LINES];
    int mtag [LINES];

    function automatic logic [DW-1:0] word_of(logic [AW-1:0] a);
        return (32'(a) * 32'h0100_0193) ^ 32'hA5A5_0000;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++; errors++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                finish_run();
            end
        end
    end

    // Backing memory with variable ready stall and response delay (R6 hold).
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_valid) begin
                logic [AW-1:0] a;
                a = mem_req_addr;
                if (act_n < 64) act_miss[act_n] = a;
                act_n++;
                for (int s = 0; s < stall; s++) begin
                    @(negedge clk);
                    chk(mem_req_valid && mem_req_addr == a, "R6", "request hold",
                        mem_req_addr, a);
                end
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                for (int s = 0; s < lat; s++) @(negedge clk);
                mem_rsp_data  = word_of(a);
                mem_rsp_valid = 1'b1;
            end
        end
    end

    // One request: model prediction, drive, wait, compare.
    task automatic run_req(logic [LANES-1:0] m, logic [AW-1:0] ad [LANES], bit poke);
        logic [LANES-1:0] done_l;
        int n_sub, n_miss, cyc;
        logic [LANES*AW-1:0] flat;
        n_sub = 0; n_miss = 0; exp_n = 0; done_l = '0;
        for (int i = 0; i < LANES; i++) begin
            flat[i*AW +: AW] = ad[i];
            if (m[i] && !done_l[i]) begin
                int idx, tg;
                idx = int'(ad[i]) % LINES;
                tg  = int'(ad[i]) / LINES;
                n_sub++;
                if (!(mval[idx] && mtag[idx] == tg)) begin
                    n_miss++;
                    exp_miss[exp_n] = ad[i];
                    exp_n++;
                    mval[idx] = 1'b1;
                    mtag[idx] = tg;
                end
                for (int j = i; j < LANES; j++)
                    if (m[j] && ad[j] == ad[i]) done_l[j] = 1'b1;
            end
        end
        while (!req_ready) @(negedge clk);
        act_n = 0;
        req_mask = m; req_addr = flat; req_valid = 1'b1;
        @(negedge clk);
        cyc = 1;
        if (poke) begin
            // R8: new inputs while busy must be ignored.
            req_mask = ~m; req_addr = ~flat;
            chk(!req_ready, "R8", "ready while busy", req_ready, 0);
            @(negedge clk); cyc++;
        end
        req_valid = 1'b0;
        while (!done && cyc < 400) begin @(negedge clk); cyc++; end
        chk(done, "R8", "done seen", done, 1);
        if (n_miss == 0)
            chk(cyc == n_sub + 2, "R7", "hit latency", cyc, n_sub + 2);
        chk(sub_count == CW'(n_sub), "R3", "sub_count", sub_count, n_sub);
        chk(miss_count == CW'(n_miss), "R4", "miss_count", miss_count, n_miss);
        begin
            bit ok; ok = 1;
            for (int i = 0; i < LANES; i++) begin
                logic [DW-1:0] e;
                e = m[i] ? word_of(ad[i]) : '0;
                if (result[i*DW +: DW] !== e) begin
                    ok = 0;
                    chk(0, "R2", $sformatf("lane %0d", i), result[i*DW +: DW], e);
                end
            end
            if (ok) chk(1, "R2", "lanes", 0, 0);
        end
        begin
            bit ok; ok = (act_n == exp_n);
            for (int k = 0; k < exp_n && k < act_n; k++)
                if (act_miss[k] != exp_miss[k]) ok = 0;
            chk(ok, "R6", "miss order", act_n, exp_n);
        end
        @(negedge clk);
        chk(!done && req_ready, "R8", "done one cycle then idle", done, 0);
    endtask

    initial begin
        logic [AW-1:0] ad [LANES];
        for (int i = 0; i < LINES; i++) begin mval[i] = 1'b0; mtag[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done && !mem_req_valid, "R1", "reset outputs",
            {req_ready, done, mem_req_valid}, 3'b100);

        // R1/R3: all lanes on one address, first miss then hit with one access.
        for (int i = 0; i < LANES; i++) ad[i] = 6'd21;
        run_req('1, ad, 0);
        chk(miss_count == 1, "R1", "cold miss", miss_count, 1);
        run_req('1, ad, 0);

        // R3/R7: fully divergent addresses, cold then warm.
        for (int i = 0; i < LANES; i++) ad[i] = AW'(i);
        run_req('1, ad, 0);
        run_req('1, ad, 0);

        // R7: empty mask.
        run_req('0, ad, 0);

        // R5: aliasing addresses replace each other in one line.
        ad[0] = 6'd3; ad[1] = 6'd11; ad[2] = 6'd3; ad[3] = 6'd19;
        for (int i = 4; i < LANES; i++) ad[i] = 6'd3;
        stall = 2; lat = 1;
        run_req(8'h0F, ad, 0);
        ad[0] = 6'd11;
        run_req(8'h01, ad, 0);
        chk(miss_count == 1, "R5", "replaced line misses", miss_count, 1);

        // R8: busy inputs ignored.
        for (int i = 0; i < LANES; i++) ad[i] = AW'(40 + (i % 3));
        run_req(8'hB7, ad, 1);

        // Sweep every mask with repeating and aliasing address patterns.
        for (int k = 0; k < 256; k++) begin
            stall = k % 3; lat = k % 4;
            for (int i = 0; i < LANES; i++)
                ad[i] = AW'(((i * (k % 5 + 1)) % (k % 4 + 2)) * 8 + (k % 7) + (i % 2) * LINES);
            run_req(LANES'(k), ad, (k % 17) == 0);
        end
        finish_run();
    end
endmodule